// File: doc/BRIEF.md
# Multiplexed Bidirectional Port Bit Array

This block is a general-purpose parallel port of up to eight pins for a small controller core. Software reaches it over a plain register bus. Each pin has an output data latch and a direction latch. A third register holds the analog-select bits for the pins that can be analog. For every pin the block drives an output-enable and an output value. On a read of the data address it returns the pin level after a two-flop synchronizer.

A peripheral attached to the port can take control of any pin in three separate ways. It can replace the latch as the source of the output value. It can force the pin's direction. It can block the digital input path so that a read of that bit returns 0.

Pins marked analog-capable come out of reset in analog-input mode. In that mode the driver is off and the bit reads as 0. The pin becomes digital only after software clears its analog-select bit.

Top module: `gpio_port_mux`

## Requirements
- R1: After reset every direction bit is 1 and every data latch bit is 0. The analog-select register equals the parameter ANA_MASK, no pin drives (pad_oe = 0 when no override is active), and data-address reads return 0 for analog pins.
- R2: Register map on bus_addr: 0 is the data latch, 1 is direction, 2 is analog select, and 3 is unused. A write with bus_we high takes effect at the next rising clk edge. Reads are combinational. Address 1 returns the direction latch and address 2 returns analog select. Address 3 returns 0 and ignores writes.
- R3: A direction value of 1 means input and 0 means output. pad_oe[i] is 1 exactly when the effective direction of pin i is 0 and the pin is not analog. Each bit is independent of the others.
- R4: pad_out[i] equals per_out[i] when per_own[i] is 1, and equals the data latch bit otherwise.
- R5: When per_dir_en[i] is 1, the effective direction of pin i is per_dir[i] and the direction latch is ignored.
- R6: When per_in_dis[i] is 1, bit i of a data-address read is 0 whatever the pin level.
- R7: A pin whose analog-select bit is 1 never drives and reads 0 at address 0. Only bits set in ANA_MASK can be written to 1 in the analog-select register. The other bits stay 0.
- R8: A change on pad_in appears in the data-address read after the second rising clk edge that follows it, and not after the first.
- R9: A write to address 0 updates the latch even for input pins. The value shows on pad_out when the pin later becomes an output. The latch changes only on such a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data for bus_addr |
| pad_in | input | WIDTH | Raw pin levels |
| pad_oe | output | WIDTH | Per-pin driver enable |
| pad_out | output | WIDTH | Per-pin output value |
| per_own | input | WIDTH | Peripheral supplies the output value |
| per_out | input | WIDTH | Peripheral output values |
| per_dir_en | input | WIDTH | Peripheral direction override enable |
| per_dir | input | WIDTH | Peripheral direction value (1 = input) |
| per_in_dis | input | WIDTH | Peripheral disables digital input |

## Verification
The assertions check the following on every cycle:
- the output source selection;
- that an override to input or an analog bit never drives;
- that a disabled input reads 0;
- that direction writes land on the next edge;
- that the data latch holds between writes.

Only the bench's scenarios can show these:
- the reset values;
- the two-edge synchronizer latency;
- the masking of non-capable analog bits;
- a latch written while a pin is an input appearing once the pin is turned to output.

Random peripheral-control mixes, run against a reference model, cover how the three takeover controls combine.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_ANA  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d.meta   = async_in;
        s_d.stable = s_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sync_out = s_q.stable;
endmodule

// File: rtl/gpio_pin_ctl.sv
module gpio_pin_ctl (
    input  logic lat,
    input  logic dir,
    input  logic ana,
    input  logic own,
    input  logic pout,
    input  logic dir_en,
    input  logic dir_val,
    input  logic in_dis,
    input  logic pin_sync,
    output logic oe,
    output logic out,
    output logic rd
);
    logic dir_eff;

    always_comb begin
        dir_eff = dir_en ? dir_val : dir;
        oe      = !dir_eff && !ana;
        out     = own ? pout : lat;
        rd      = pin_sync && !ana && !in_dis;
    end
endmodule

// File: rtl/gpio_port_mux.sv
module gpio_port_mux #(
    parameter int          WIDTH    = 8,
    parameter logic [7:0]  ANA_MASK = 8'h0F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic [1:0]       bus_addr,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic [WIDTH-1:0] bus_rdata,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_out,
    input  logic [WIDTH-1:0] per_own,
    input  logic [WIDTH-1:0] per_out,
    input  logic [WIDTH-1:0] per_dir_en,
    input  logic [WIDTH-1:0] per_dir,
    input  logic [WIDTH-1:0] per_in_dis
);
    import gpio_port_pkg::*;

    localparam logic [WIDTH-1:0] CAP_MASK = ANA_MASK[WIDTH-1:0];

    typedef struct packed {
        logic [WIDTH-1:0] lat;
        logic [WIDTH-1:0] dir;
        logic [WIDTH-1:0] ana;
    } port_state_t;

    port_state_t st_d, st_q;
    logic [WIDTH-1:0] pin_sync;
    logic [WIDTH-1:0] rd_bits;
    logic [WIDTH-1:0] lat_q, dir_q, ana_q;

    always_comb begin
        st_d = st_q;
        if (bus_we) begin
            unique case (reg_sel_e'(bus_addr))
                SEL_DATA: st_d.lat = bus_wdata;
                SEL_DIR:  st_d.dir = bus_wdata;
                SEL_ANA:  st_d.ana = bus_wdata & CAP_MASK;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lat <= '0;
            st_q.dir <= '1;
            st_q.ana <= CAP_MASK;
        end else begin
            st_q <= st_d;
        end
    end

    assign lat_q = st_q.lat;
    assign dir_q = st_q.dir;
    assign ana_q = st_q.ana;

    gpio_in_sync #(.WIDTH(WIDTH)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pin_sync)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        gpio_pin_ctl u_pin (
            .lat      (st_q.lat[i]),
            .dir      (st_q.dir[i]),
            .ana      (st_q.ana[i]),
            .own      (per_own[i]),
            .pout     (per_out[i]),
            .dir_en   (per_dir_en[i]),
            .dir_val  (per_dir[i]),
            .in_dis   (per_in_dis[i]),
            .pin_sync (pin_sync[i]),
            .oe       (pad_oe[i]),
            .out      (pad_out[i]),
            .rd       (rd_bits[i])
        );
    end

    always_comb begin
        unique case (reg_sel_e'(bus_addr))
            SEL_DATA: bus_rdata = rd_bits;
            SEL_DIR:  bus_rdata = st_q.dir;
            SEL_ANA:  bus_rdata = st_q.ana;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_port_mux_chk.sv
module gpio_port_mux_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_we,
    input logic [1:0]       bus_addr,
    input logic [WIDTH-1:0] bus_wdata,
    input logic [WIDTH-1:0] bus_rdata,
    input logic [WIDTH-1:0] pad_oe,
    input logic [WIDTH-1:0] pad_out,
    input logic [WIDTH-1:0] per_own,
    input logic [WIDTH-1:0] per_out,
    input logic [WIDTH-1:0] per_dir_en,
    input logic [WIDTH-1:0] per_dir,
    input logic [WIDTH-1:0] per_in_dis,
    input logic [WIDTH-1:0] lat_q,
    input logic [WIDTH-1:0] dir_q,
    input logic [WIDTH-1:0] ana_q
);
    a_r2_dir_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 2'd1) |=> (dir_q == $past(bus_wdata)));

    a_r4_owned_out_source: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_out ^ per_out) & per_own) == '0);

    a_r5_override_input_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & per_dir_en & per_dir) == '0);

    a_r6_disabled_input_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd0) |-> ((bus_rdata & per_in_dis) == '0));

    a_r7_analog_never_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ana_q) == '0);

    a_r9_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == 2'd0) |=> $stable(lat_q));
endmodule

bind gpio_port_mux gpio_port_mux_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .pad_oe     (pad_oe),
    .pad_out    (pad_out),
    .per_own    (per_own),
    .per_out    (per_out),
    .per_dir_en (per_dir_en),
    .per_dir    (per_dir),
    .per_in_dis (per_in_dis),
    .lat_q      (lat_q),
    .dir_q      (dir_q),
    .ana_q      (ana_q)
);

// File: tb/sim_gpio_port_mux.sv
`timescale 1ns/1ps
module sim_gpio_port_mux;
    localparam int         W    = 8;
    localparam logic [7:0] MASK = 8'h0F;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_we = 1'b0;
    logic [1:0]   bus_addr = 2'd0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic [W-1:0] pad_in = '0;
    logic [W-1:0] pad_oe, pad_out;
    logic [W-1:0] per_own = '0, per_out = '0, per_dir_en = '0, per_dir = '0, per_in_dis = '0;

    logic [W-1:0] m_lat, m_dir, m_ana;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    gpio_port_mux #(.WIDTH(W), .ANA_MASK(MASK)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .per_own(per_own), .per_out(per_out),
        .per_dir_en(per_dir_en), .per_dir(per_dir), .per_in_dis(per_in_dis)
    );

    function automatic logic [W-1:0] exp_oe();
        logic [W-1:0] eff = (per_dir_en & per_dir) | (~per_dir_en & m_dir);
        return ~eff & ~m_ana;
    endfunction

    function automatic logic [W-1:0] exp_out();
        return (per_own & per_out) | (~per_own & m_lat);
    endfunction

    function automatic logic [W-1:0] exp_rd0();
        return pad_in & ~m_ana & ~per_in_dis;
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [W-1:0] v);
        bus_addr = a;
        #0.2;
        v = bus_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #0.5;
        bus_we = 1'b0;
        case (a)
            2'd0: m_lat = d;
            2'd1: m_dir = d;
            2'd2: m_ana = d & MASK;
            default: ;
        endcase
    endtask

    task automatic check_all(input string tag);
        logic [W-1:0] v;
        chk({tag, " R3/R5 pad_oe"}, pad_oe, exp_oe());
        chk({tag, " R4 pad_out"}, pad_out, exp_out());
        rd(2'd0, v); chk({tag, " R6/R7 data read"}, v, exp_rd0());
        rd(2'd1, v); chk({tag, " R2 dir read"}, v, m_dir);
        rd(2'd2, v); chk({tag, " R7 analog read"}, v, m_ana);
        rd(2'd3, v); chk({tag, " R2 unused read"}, v, '0);
    endtask

    initial begin : watchdog
        #(4 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [W-1:0] v;
        void'($urandom(32'h5EED_0042));
        m_lat = '0; m_dir = '1; m_ana = MASK;
        pad_in = 8'hFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        chk("R1 pad_oe after reset", pad_oe, '0);
        chk("R1 pad_out after reset", pad_out, '0);
        rd(2'd1, v); chk("R1 dir reset", v, 8'hFF);
        rd(2'd2, v); chk("R1 analog reset", v, MASK);
        rd(2'd0, v); chk("R1 analog pins read 0", v, 8'hF0);

        // R7 non-capable bits stay 0 in analog select
        wr(2'd2, 8'hFF);
        rd(2'd2, v); chk("R7 analog mask", v, MASK);

        // R2 unused address ignores writes
        wr(2'd3, 8'h5A);
        check_all("R2 after unused write");

        // R9 latch written while input, appears once output
        wr(2'd2, 8'h00);
        wr(2'd0, 8'hA5);
        @(negedge clk);
        chk("R9 oe while input", pad_oe, '0);
        chk("R9 latch on pad_out", pad_out, 8'hA5);
        wr(2'd1, 8'h00);
        @(negedge clk);
        chk("R9 oe after switch", pad_oe, 8'hFF);
        chk("R9 value after switch", pad_out, 8'hA5);

        // R3 independent bits
        wr(2'd1, 8'h3C);
        @(negedge clk);
        chk("R3 mixed directions", pad_oe, 8'hC3);

        // R8 two-edge synchronizer latency
        pad_in = 8'h00;
        repeat (3) @(negedge clk);
        rd(2'd0, v); chk("R8 settled low", v, 8'h00);
        pad_in = 8'h96;
        @(negedge clk);
        rd(2'd0, v); chk("R8 not after one edge", v, 8'h00);
        @(negedge clk);
        rd(2'd0, v); chk("R8 after two edges", v, 8'h96);

        // R5 override beats latch, R6 input disable, R4 source select
        per_dir_en = 8'hFF; per_dir = 8'hF0;
        per_in_dis = 8'h81; per_own = 8'h0F; per_out = 8'h05;
        @(negedge clk);
        check_all("R4/R5/R6 directed");

        // random mixes
        for (int it = 0; it < 400; it++) begin
            @(negedge clk);
            per_own    = W'($urandom);
            per_out    = W'($urandom);
            per_dir_en = W'($urandom);
            per_dir    = W'($urandom);
            per_in_dis = W'($urandom);
            pad_in     = W'($urandom);
            if ($urandom_range(0, 1) == 1)
                wr(2'($urandom_range(0, 3)), W'($urandom));
            repeat (2) @(negedge clk);
            check_all("random");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule